// File: doc/BRIEF.md
# Flash status and write-protect unit

This unit keeps the status register and sector write protection of a serial flash with eight equal 64 KB sectors in a 512 KB array. A command decoder hands it one decoded command per cycle (qualified by `cmd_valid_i`) along with a 19-bit byte address, the data byte of a status write and the level of the external write-protect pin. The unit answers register reads and ID reads, and it decides whether each array write or status write may go ahead.

Accepted writes are self-timed. The unit holds a busy window of `BUSY_CYCLES` clock cycles. While that window is open the status byte reads as all ones and only status reads are served. When the window closes the write-enable latch drops. A status write only commits its new protect bits when the window closes.

Protection grows downward from the top of the array: the top eighth, then the top quarter, then the top half, then the whole array. A hardware lock, made from a low pin together with a protect-enable bit, freezes the status register.

Top module: `flash_prot_unit`

## Requirements
- R1: After reset the status read returns WEN=0, RDY=0, the protect-level bits equal to `POR_BP` and the protect-enable bit equal to `POR_WPEN`.
- R2: The command codes on `cmd_i` are 0 none, 1 read status, 2 write status, 3 write enable, 4 read ID, 5 array write. A read status command yields `rd_valid_o`=1 one cycle later. `rd_data_o[15:8]` is 0. `rd_data_o[7:0]` holds bit0 RDY, bit1 WEN, bits 4:2 the protect level, bits 6:5 zero and bit7 the protect-enable bit.
- R3: While busy, a read status command returns 0xFF in `rd_data_o[7:0]`.
- R4: Write enable, when not busy, sets WEN.
- R5: An array write gives `wr_ack_o`=1 one cycle later. `wr_ok_o` is 1 only if WEN=1 and the address lies outside the locked range. Level 0 locks nothing. Level 1 locks 0x70000 and above. Level 2 locks 0x60000 and above. Level 3 locks 0x40000 and above. Levels 4 to 7 lock the whole array.
- R6: A rejected write starts no busy window and changes neither WEN nor the protect bits.
- R7: A write status command is rejected when `wp_ni` is low and the protect-enable bit is 1. Otherwise it is accepted when WEN=1. Its ack and result appear on `wr_ack_o`/`wr_ok_o` one cycle later.
- R8: Read ID returns `rd_data_o`=0x1F64: first byte 0x1F in the upper half, second byte 0x64 in the lower half.
- R9: An accepted write keeps the unit busy for `BUSY_CYCLES` cycles after the command edge. At the end WEN clears. For a status write, the protect level takes data bits 4:2 and the protect-enable bit takes data bit 7.
- R10: While busy, every command other than read status is ignored: no response, no ack, no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command present this cycle |
| cmd_i | input | 3 | Command code |
| addr_i | input | 19 | Byte address of an array write |
| sr_data_i | input | 8 | Data byte of a status write |
| wp_ni | input | 1 | Write-protect pin level, low asserts |
| rd_valid_o | output | 1 | Read response valid |
| rd_data_o | output | 16 | Status byte or ID bytes |
| wr_ack_o | output | 1 | Write command answered |
| wr_ok_o | output | 1 | Write accepted, valid with wr_ack_o |

## Verification
Array writes are applied at the first and last byte of each protection boundary (0x00000, 0x3FFFF, 0x40000, 0x5FFFF, 0x60000, 0x6FFFF, 0x70000, 0x7FFFF) under all eight protect-level values. This exposes an off-by-one boundary and a wrong decode of the levels with the top bit set. Status writes are tried with the pin low and high and with the protect-enable bit clear and set, which separates the hardware lock from the WEN check. Commands issued inside a busy window show whether reads return all ones and whether other commands leak through. Status reads after each write show whether WEN and the new protect bits change at the window's end rather than at its start.

// File: rtl/flash_prot_pkg.sv
package flash_prot_pkg;
  typedef enum logic [2:0] {
    CMD_NONE  = 3'd0,
    CMD_RDSR  = 3'd1,
    CMD_WRSR  = 3'd2,
    CMD_WREN  = 3'd3,
    CMD_RDID  = 3'd4,
    CMD_ARRWR = 3'd5
  } cmd_e;

  localparam logic [7:0] ID_FIRST  = 8'h1F;
  localparam logic [7:0] ID_SECOND = 8'h64;
endpackage

// File: rtl/fp_lock_decode.sv
module fp_lock_decode #(
  parameter int ADDR_W  = 19,
  parameter int SECTORS = 8
) (
  input  logic [2:0]        bp_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              locked_o
);
  localparam int SEC_W   = $clog2(SECTORS);
  localparam int SHIFT   = ADDR_W - SEC_W;
  localparam int LIM_W   = ADDR_W + 1;

  logic [SEC_W:0] n_lock;
  logic [SEC_W:0] first_sec;
  logic [LIM_W-1:0] limit;

  // levels 1..3 lock 1, 2, 4 top sectors; level 4+ locks all
  always_comb begin
    if (bp_i == 3'd0)     n_lock = '0;
    else if (bp_i[2])     n_lock = (SEC_W+1)'(SECTORS);
    else                  n_lock = (SEC_W+1)'(SECTORS >> (4 - int'(bp_i)));
    first_sec = (SEC_W+1)'(SECTORS) - n_lock;
    limit     = LIM_W'(first_sec) << SHIFT;
  end

  assign locked_o = ({1'b0, addr_i} >= limit);
endmodule

// File: rtl/fp_busy_timer.sv
module fp_busy_timer #(
  parameter int BUSY_CYCLES = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(BUSY_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             busy_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
    end else if (start_i && !busy_q) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(BUSY_CYCLES - 1);
    end else if (busy_q) begin
      if (cnt_q == '0) busy_q <= 1'b0;
      else             cnt_q  <= cnt_q - 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == '0);

  AST_START_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !busy_q |=> busy_o); // R9
  AST_DONE_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !busy_o); // R9
endmodule

// File: rtl/fp_status_regs.sv
module fp_status_regs #(
  parameter logic [2:0] POR_BP   = 3'b000,
  parameter logic       POR_WPEN = 1'b0
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wen_set_i,
  input  logic       wr_start_i,
  input  logic       sr_start_i,
  input  logic [7:0] sr_data_i,
  input  logic       done_i,
  output logic       wen_o,
  output logic [2:0] bp_o,
  output logic       wpen_o
);
  logic       wen_q, wpen_q, pend_q, pend_wpen_q;
  logic [2:0] bp_q, pend_bp_q;
  logic       unused_bits;

  assign unused_bits = ^{sr_data_i[6:5], sr_data_i[1:0]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wen_q       <= 1'b0;
      bp_q        <= POR_BP;
      wpen_q      <= POR_WPEN;
      pend_q      <= 1'b0;
      pend_bp_q   <= '0;
      pend_wpen_q <= 1'b0;
    end else begin
      if (wen_set_i) wen_q <= 1'b1;
      if (wr_start_i) begin
        pend_q      <= sr_start_i;
        pend_bp_q   <= sr_data_i[4:2];
        pend_wpen_q <= sr_data_i[7];
      end
      if (done_i) begin
        wen_q  <= 1'b0;
        pend_q <= 1'b0;
        if (pend_q) begin
          bp_q   <= pend_bp_q;
          wpen_q <= pend_wpen_q;
        end
      end
    end
  end

  assign wen_o  = wen_q;
  assign bp_o   = bp_q;
  assign wpen_o = wpen_q;

  AST_SR_COMMIT_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !done_i |=> $stable(bp_q) && $stable(wpen_q)); // R6
  AST_WEN_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_i |=> !wen_q); // R9
endmodule

// File: rtl/flash_prot_unit.sv
module flash_prot_unit
  import flash_prot_pkg::*;
#(
  parameter int         ADDR_W      = 19,
  parameter int         SECTORS     = 8,
  parameter int         BUSY_CYCLES = 16,
  parameter logic [2:0] POR_BP      = 3'b000,
  parameter logic       POR_WPEN    = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  input  logic [2:0]        cmd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        sr_data_i,
  input  logic              wp_ni,
  output logic              rd_valid_o,
  output logic [15:0]       rd_data_o,
  output logic              wr_ack_o,
  output logic              wr_ok_o
);
  cmd_e       cmd;
  logic       busy, done, wen, wpen, locked, hw_lock;
  logic [2:0] bp;
  logic       act, is_rdsr, is_rdid, is_wren, is_wrsr, is_arr;
  logic       sr_ok, arr_ok;
  logic [7:0] status_byte;

  assign cmd     = cmd_e'(cmd_i);
  assign act     = cmd_valid_i && !busy;
  assign is_rdsr = cmd_valid_i && (cmd == CMD_RDSR);
  assign is_rdid = act && (cmd == CMD_RDID);
  assign is_wren = act && (cmd == CMD_WREN);
  assign is_wrsr = act && (cmd == CMD_WRSR);
  assign is_arr  = act && (cmd == CMD_ARRWR);
  assign hw_lock = !wp_ni && wpen;
  assign sr_ok   = is_wrsr && wen && !hw_lock;
  assign arr_ok  = is_arr && wen && !locked;

  fp_lock_decode #(.ADDR_W(ADDR_W), .SECTORS(SECTORS)) u_lock (
    .bp_i     (bp),
    .addr_i   (addr_i),
    .locked_o (locked)
  );

  fp_busy_timer #(.BUSY_CYCLES(BUSY_CYCLES)) u_timer (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (sr_ok || arr_ok),
    .busy_o  (busy),
    .done_o  (done)
  );

  fp_status_regs #(.POR_BP(POR_BP), .POR_WPEN(POR_WPEN)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wen_set_i  (is_wren),
    .wr_start_i (sr_ok || arr_ok),
    .sr_start_i (sr_ok),
    .sr_data_i  (sr_data_i),
    .done_i     (done),
    .wen_o      (wen),
    .bp_o       (bp),
    .wpen_o     (wpen)
  );

  // all ones while a self-timed write runs
  assign status_byte = busy ? 8'hFF : {wpen, 2'b00, bp, wen, 1'b0};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_valid_o <= 1'b0;
      rd_data_o  <= '0;
      wr_ack_o   <= 1'b0;
      wr_ok_o    <= 1'b0;
    end else begin
      rd_valid_o <= is_rdsr || is_rdid;
      if (is_rdid)      rd_data_o <= {ID_FIRST, ID_SECOND};
      else if (is_rdsr) rd_data_o <= {8'h00, status_byte};
      wr_ack_o <= is_wrsr || is_arr;
      wr_ok_o  <= sr_ok || arr_ok;
    end
  end

  AST_BUSY_ONES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_valid_i && cmd_i == 3'd1 && busy |=> rd_data_o == 16'h00FF); // R3
  AST_LOCKED_DENY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && cmd_i == 3'd5 && locked |=> wr_ack_o && !wr_ok_o); // R5
  AST_HW_LOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && cmd_i == 3'd2 && !wp_ni && wpen |=> !wr_ok_o); // R7
  AST_ID_BYTES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    act && cmd_i == 3'd4 |=> rd_data_o == 16'h1F64); // R8
  AST_BUSY_IGNORE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy && cmd_valid_i && cmd_i != 3'd1 |=> !rd_valid_o && !wr_ack_o); // R10
  AST_REJECT_NO_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy && !(sr_ok || arr_ok) |=> !busy); // R6
endmodule

// File: tb/flash_prot_unit_bench.sv
module flash_prot_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUSY       = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd = 3'd0;
  logic [18:0] addr = '0;
  logic [7:0]  sr_data = '0;
  logic        wp_n = 1'b1;
  logic        rd_valid, wr_ack, wr_ok;
  logic [15:0] rd_data;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  int m_busy = 0;
  int m_cnt = 0;
  int m_wen = 0;
  int m_bp = 3;
  int m_wpen = 1;
  int m_pend = 0;
  int m_pbp = 0;
  int m_pwpen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_prot_unit #(.BUSY_CYCLES(BUSY), .POR_BP(3'b011), .POR_WPEN(1'b1)) u_flash_prot_unit (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_i(cmd),
    .addr_i(addr), .sr_data_i(sr_data), .wp_ni(wp_n),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .wr_ack_o(wr_ack), .wr_ok_o(wr_ok)
  );

  function automatic bit in_lock(int bpv, int a);
    int nl;
    if (bpv == 0) nl = 0;
    else if (bpv >= 4) nl = 8;
    else nl = 1 << (bpv - 1);
    return (a / 65536) >= (8 - nl);
  endfunction

  task automatic step(input int c, input bit v, input int a, input int d, input bit wp, input string tag);
    logic [15:0] e_rd;
    bit e_rdv, e_ack, e_ok;
    int st;
    cmd = 3'(c); cmd_valid = v; addr = 19'(a); sr_data = 8'(d); wp_n = wp;
    e_rdv = 0; e_ack = 0; e_ok = 0; e_rd = 16'hxxxx;
    st = m_busy ? 255 : (m_wpen * 128 + m_bp * 4 + m_wen * 2);
    if (v) begin
      if (c == 1) begin e_rdv = 1; e_rd = 16'(st); end
      else if (!m_busy) begin
        if (c == 4) begin e_rdv = 1; e_rd = 16'h1F64; end
        else if (c == 2) begin
          e_ack = 1; e_ok = m_wen && !(!wp && m_wpen);
        end else if (c == 5) begin
          e_ack = 1; e_ok = m_wen && !in_lock(m_bp, a);
        end
      end
    end
    @(posedge clk);
    @(negedge clk);
    checks++;
    if (rd_valid !== e_rdv || wr_ack !== e_ack || wr_ok !== e_ok ||
        (e_rdv && rd_data !== e_rd)) begin
      errors++;
      $display("FAIL %s: rdv=%b rd=%h ack=%b ok=%b exp rdv=%b rd=%h ack=%b ok=%b",
               tag, rd_valid, rd_data, wr_ack, wr_ok, e_rdv, e_rd, e_ack, e_ok);
    end
    // advance the model
    if (m_busy) begin
      if (m_cnt == 0) begin
        m_busy = 0; m_wen = 0;
        if (m_pend) begin m_bp = m_pbp; m_wpen = m_pwpen; end
        m_pend = 0;
      end else m_cnt--;
    end else if (v) begin
      if (c == 3) m_wen = 1;
      if (e_ok) begin
        m_busy = 1; m_cnt = BUSY - 1; m_pend = (c == 2);
        m_pbp = (d >> 2) & 7; m_pwpen = (d >> 7) & 1;
      end
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) step(0, 0, 0, 0, 1, "R9");
  endtask

  initial begin
    int addrs[8];
    addrs = '{32'h00000, 32'h3FFFF, 32'h40000, 32'h5FFFF,
              32'h60000, 32'h6FFFF, 32'h70000, 32'h7FFFF};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    step(1, 1, 0, 0, 1, "R1");            // reset status 0x8C
    step(4, 1, 0, 0, 1, "R8");
    step(5, 1, 0, 0, 1, "R6");            // no WEN, rejected
    step(1, 1, 0, 0, 1, "R6");
    step(3, 1, 0, 0, 1, "R4");
    step(1, 1, 0, 0, 1, "R2");
    step(2, 1, 0, 8'h00, 0, "R7");        // pin low + WPEN -> rejected
    step(1, 1, 0, 0, 1, "R6");
    step(2, 1, 0, 8'h88, 1, "R7");        // accepted: level 2, WPEN 1
    step(1, 1, 0, 0, 1, "R3");
    step(3, 1, 0, 0, 1, "R10");
    step(4, 1, 0, 0, 1, "R10");
    idle(2);
    step(1, 1, 0, 0, 1, "R9");
    step(5, 1, 32'h10000, 0, 1, "R10");
    step(3, 1, 0, 0, 1, "R4");
    step(2, 1, 0, 8'h00, 0, "R7");
    step(2, 1, 0, 8'h00, 1, "R7");        // clears WPEN
    idle(BUSY);
    step(3, 1, 0, 0, 1, "R4");
    step(2, 1, 0, 8'h04, 0, "R7");        // WPEN 0: pin ignored
    idle(BUSY);
    step(1, 1, 0, 0, 1, "R9");
    for (int lv = 0; lv < 8; lv++) begin
      step(3, 1, 0, 0, 1, "R4");
      step(2, 1, 0, lv << 2, 1, "R7");
      idle(BUSY);
      step(1, 1, 0, 0, 1, "R2");
      for (int k = 0; k < 8; k++) begin
        step(3, 1, 0, 0, 1, "R4");
        step(5, 1, addrs[k], 0, 0, "R5");
        idle(BUSY);
        step(1, 1, 0, 0, 1, "R6");
      end
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule